// File: doc/BRIEF.md
# I2C Slave Register-File Window

This block is an I2C target that presents a 32-byte memory to an external bus master. The master selects a byte offset with the first data byte of a write transfer. Each further written byte is stored at that offset, and the offset then advances by one. A read transfer returns bytes from the current offset and advances after each byte. The offset persists across transfers and repeated STARTs, so the usual access is a write of the offset, a repeated START, and then a read.

The block never holds SCL low. It acknowledges bytes on its own, without waiting on the local processor. The processor has a separate port into the same memory. It uses this port to preload bytes for the master to read and to collect bytes the master wrote. When enabled, a STOP that closes a transfer addressed to this device raises a one-cycle interrupt pulse. A level output then records whether that transfer ended as a read or a write.

SCL and SDA are sampled on the local clock through synchronizers, so the local clock must run well above the bus bit rate. SDA is driven open-drain through a single pull-low output.

Top module: `i2c_rf_slave`

## Requirements
- R1: A 7-bit address equal to DEV_ADDR (default 0x2A) is acknowledged in the ninth bit. Any other address gets no acknowledge, and the block then ignores all traffic until the next START.
- R2: In a write transfer, the first data byte after the address sets the byte offset. Each later byte is stored at the offset and acknowledged, and the offset then increments by one.
- R3: A read transfer returns the byte at the current offset, then the following bytes in order. The offset is the one left by the previous transfer, including one set before a repeated START.
- R4: An offset value of 32 or above is out of range, whether it was loaded or reached by incrementing. Writes at an out-of-range offset are not acknowledged and not stored. Reads at an out-of-range offset return 0xFF. Incrementing stops at 32.
- R5: The block changes its SDA pull-low output only while SCL is low.
- R6: After the master does not acknowledge a read byte, the block leaves SDA released until the next START.
- R7: A STOP that ends a transfer addressed to this device gives a single-cycle pulse on stop_irq when irq_en is 1. It also sets last_rd to 1 for a read transfer or 0 for a write transfer. There is no pulse when irq_en is 0, or when the transfer was not addressed to this device.
- R8: A processor write stores cpu_wdata at cpu_addr. A processor read returns the byte at cpu_addr on cpu_rdata one clock later. Bytes the master wrote can be read through this port.
- R9: A processor write to the byte being shifted out on the bus does not change that byte. The next byte sent is fetched from memory at its own byte boundary, so it reflects earlier processor writes.
- R10: After reset, SDA is released, stop_irq and last_rd are 0, every memory byte is 0x00 and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| cpu_addr | input | $clog2(DEPTH) | Processor byte index |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, one clock after cpu_addr |
| irq_en | input | 1 | Enables the STOP interrupt pulse |
| stop_irq | output | 1 | One-cycle pulse on STOP of an addressed transfer |
| last_rd | output | 1 | Direction of the last addressed transfer, 1 for read |

## Verification
The bench runs a set of directed tests:
- a plain write burst, checked through the processor port;
- an offset write followed by a repeated-START read, which separates persistence of the offset from its reset value;
- a read with no offset byte, which shows that the offset kept advancing from the earlier read;
- a foreign address, which must draw no SDA activity at all;
- an offset loaded at 30, which walks the offset across the end of the memory and tells an acknowledged store apart from an acknowledge withheld with the byte dropped;
- an offset loaded at 40, which checks that a loaded value out of range reads as 0xFF;
- a processor write made in the middle of a byte, which tells the latched byte apart from the fetch of the next byte;
- STOPs with the interrupt enabled and disabled.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } eng_st_t;

  localparam logic [7:0] RD_FILL = 8'hFF;

  function automatic logic addr_hit(input logic [6:0] got, input logic [6:0] own);
    return got == own;
  endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2c_rf_ram.sv
module i2c_rf_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [7:0]    b_wdata,
  input  logic [AW-1:0] b_raddr,
  output logic [7:0]    b_rdata,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_wdata,
  output logic [7:0]    c_rdata
);
  logic [7:0] mem [DEPTH];
  logic       clash;

  // same byte written by both sides in one cycle: the bus value is kept
  assign clash   = b_we && c_we && (b_waddr == c_addr);
  assign b_rdata = mem[b_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      c_rdata <= 8'h00;
    end else begin
      if (c_we && !clash) mem[c_addr] <= c_wdata;
      if (b_we) mem[b_waddr] <= b_wdata;
      c_rdata <= mem[c_addr];
    end
  end
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int          DEPTH    = 32,
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int          AW       = $clog2(DEPTH),
  parameter int          PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          irq_en,
  input  logic [7:0]    bus_rdata,
  output logic [AW-1:0] bus_raddr,
  output logic          bus_we,
  output logic [AW-1:0] bus_waddr,
  output logic [7:0]    bus_wdata,
  output logic          sda_low,
  output logic [PW-1:0] ptr,
  output logic          stop_irq,
  output logic          last_rd
);
  eng_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh, tx_sh, fetch, rx_byte;
  logic       first_data, rw_q, from_addr, ack_pend, m_ack, addressed;

  function automatic logic [PW-1:0] ptr_from_byte(input logic [7:0] b);
    return (32'(b) >= DEPTH) ? PW'(DEPTH) : PW'(b);
  endfunction

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (32'(p) >= DEPTH) ? p : p + PW'(1);
  endfunction

  function automatic logic ptr_ok(input logic [PW-1:0] p);
    return 32'(p) < DEPTH;
  endfunction

  assign bus_raddr = ptr[AW-1:0];
  assign fetch     = ptr_ok(ptr) ? bus_rdata : RD_FILL;
  assign rx_byte   = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx_sh <= '0;
      first_data <= 1'b0; rw_q <= 1'b0; from_addr <= 1'b0;
      ack_pend <= 1'b0; m_ack <= 1'b0; addressed <= 1'b0;
      ptr <= '0; sda_low <= 1'b0; stop_irq <= 1'b0; last_rd <= 1'b0;
      bus_we <= 1'b0; bus_waddr <= '0; bus_wdata <= '0;
    end else begin
      bus_we   <= 1'b0;
      stop_irq <= 1'b0;
      if (ev_stop) begin
        if (addressed) begin
          stop_irq <= irq_en;
          last_rd  <= rw_q;
        end
        addressed <= 1'b0;
        sda_low   <= 1'b0;
        st        <= ST_IDLE;
      end else if (ev_start) begin
        addressed <= 1'b0;
        sda_low   <= 1'b0;
        cnt       <= '0;
        st        <= ST_ADDR;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh  <= rx_byte;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == ST_ADDR) begin
                  rw_q     <= sda_s;
                  ack_pend <= addr_hit(sh[6:0], DEV_ADDR);
                end else if (first_data) begin
                  ptr        <= ptr_from_byte(rx_byte);
                  first_data <= 1'b0;
                  ack_pend   <= 1'b1;
                end else if (ptr_ok(ptr)) begin
                  bus_we    <= 1'b1;
                  bus_waddr <= ptr[AW-1:0];
                  bus_wdata <= rx_byte;
                  ptr       <= ptr_step(ptr);
                  ack_pend  <= 1'b1;
                end else begin
                  ack_pend <= 1'b0;
                end
              end
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ST_ADDR && !ack_pend) begin
                st <= ST_IDLE;
              end else begin
                sda_low   <= ack_pend;
                from_addr <= (st == ST_ADDR);
                if (st == ST_ADDR) begin
                  addressed  <= 1'b1;
                  first_data <= !rw_q;
                end
                st <= ST_ACK_OUT;
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              cnt <= '0;
              if (from_addr && rw_q) begin
                tx_sh   <= fetch;
                sda_low <= ~fetch[7];
                ptr     <= ptr_step(ptr);
                st      <= ST_TX;
              end else begin
                sda_low <= 1'b0;
                st      <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_low <= 1'b0;
                st      <= ST_ACK_IN;
              end else begin
                tx_sh   <= {tx_sh[6:0], 1'b0};
                sda_low <= ~tx_sh[6];
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                cnt     <= '0;
                tx_sh   <= fetch;
                sda_low <= ~fetch[7];
                ptr     <= ptr_step(ptr);
                st      <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave #(
  parameter int         DEPTH       = 32,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_pull,
  input  logic [$clog2(DEPTH)-1:0] cpu_addr,
  input  logic                     cpu_we,
  input  logic [7:0]               cpu_wdata,
  output logic [7:0]               cpu_rdata,
  input  logic                     irq_en,
  output logic                     stop_irq,
  output logic                     last_rd
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          scl_s, scl_rise, scl_fall;
  logic          sda_s, sda_rise, sda_fall;
  logic          ev_start, ev_stop;
  logic          bus_we;
  logic [AW-1:0] bus_waddr, bus_raddr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [PW-1:0] ptr;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_in),
    .q(scl_s), .rise(scl_rise), .fall(scl_fall));

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_in),
    .q(sda_s), .rise(sda_rise), .fall(sda_fall));

  assign ev_start = sda_fall & scl_s;
  assign ev_stop  = sda_rise & scl_s;

  i2c_rf_engine #(.DEPTH(DEPTH), .DEV_ADDR(DEV_ADDR), .AW(AW), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .irq_en(irq_en),
    .bus_rdata(bus_rdata), .bus_raddr(bus_raddr),
    .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .sda_low(sda_pull), .ptr(ptr),
    .stop_irq(stop_irq), .last_rd(last_rd));

  i2c_rf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .b_we(bus_we), .b_waddr(bus_waddr), .b_wdata(bus_wdata),
    .b_raddr(bus_raddr), .b_rdata(bus_rdata),
    .c_we(cpu_we), .c_addr(cpu_addr), .c_wdata(cpu_wdata), .c_rdata(cpu_rdata));
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_pull,
  input logic [PW-1:0] ptr,
  input logic          bus_we,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          irq_en,
  input logic          stop_irq
);
  AST_SDA_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (32'(ptr) == 32'($past(ptr)) + 1)); // R2

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) <= DEPTH); // R4

  AST_NO_STORE_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (32'($past(ptr)) < DEPTH)); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> $past(ev_stop && irq_en)); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq); // R7

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull); // R6
endmodule

bind i2c_rf_slave i2c_rf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
  .ptr(ptr), .bus_we(bus_we), .ev_start(ev_start), .ev_stop(ev_stop),
  .irq_en(irq_en), .stop_irq(stop_irq));

// File: tb/sim_i2c_rf_slave.sv
module sim_i2c_rf_slave;
  localparam logic [6:0] DEV = 7'h2A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_pull;
  logic [4:0] cpu_addr = '0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       irq_en = 1'b1;
  logic       stop_irq, last_rd;
  wire        sda_bus = sda_m & ~sda_pull;

  int checks = 0, fails = 0, irq_cnt = 0, bad_edge = 0;
  logic pull_seen = 1'b0, prev_pull = 1'b0;

  always #5 clk = ~clk;

  i2c_rf_slave #(.DEPTH(32), .DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_en(irq_en),
    .stop_irq(stop_irq), .last_rd(last_rd));

  always @(posedge clk) begin
    if (stop_irq) irq_cnt <= irq_cnt + 1;
    if (sda_pull) pull_seen <= 1'b1;
    if (sda_pull != prev_pull && scl_m) bad_edge <= bad_edge + 1;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (6) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; q(); scl_m = 1'b1; q(); r = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic ack_it, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(~ack_it, r);
  endtask

  task automatic cpu_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a;
    @(negedge clk); d = cpu_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 sda released", int'(sda_pull), 0);
    chk("R10 stop_irq low", int'(stop_irq), 0);
    chk("R10 last_rd low", int'(last_rd), 0);
    cpu_rd(5'd9, d);
    chk("R10 memory zero", int'(d), 0);
  endtask

  task automatic t_write();
    logic a; logic [7:0] d; int n0;
    n0 = irq_cnt;
    m_start();
    m_wbyte({DEV, 1'b0}, a); chk("R1 own address ack", int'(a), 1);
    m_wbyte(8'd4, a);        chk("R2 offset byte ack", int'(a), 1);
    m_wbyte(8'hA1, a);       chk("R2 data ack 0", int'(a), 1);
    m_wbyte(8'hB2, a);       chk("R2 data ack 1", int'(a), 1);
    m_wbyte(8'hC3, a);       chk("R2 data ack 2", int'(a), 1);
    m_stop();
    cpu_rd(5'd4, d); chk("R2 R8 byte 4", int'(d), 'hA1);
    cpu_rd(5'd5, d); chk("R2 R8 byte 5", int'(d), 'hB2);
    cpu_rd(5'd6, d); chk("R2 R8 byte 6", int'(d), 'hC3);
    cpu_rd(5'd7, d); chk("R2 byte 7 untouched", int'(d), 0);
    chk("R7 irq on write stop", irq_cnt - n0, 1);
    chk("R7 last_rd write", int'(last_rd), 0);
  endtask

  task automatic t_read_rs();
    logic a; logic [7:0] d; int n0;
    n0 = irq_cnt;
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd5, a);
    m_start();
    m_wbyte({DEV, 1'b1}, a); chk("R1 read address ack", int'(a), 1);
    m_rbyte(1'b1, d);        chk("R3 read byte 5", int'(d), 'hB2);
    m_rbyte(1'b0, d);        chk("R3 read byte 6", int'(d), 'hC3);
    pull_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      logic r;
      m_bit(1'b1, r);
    end
    chk("R6 released after master nack", int'(pull_seen), 0);
    m_stop();
    chk("R7 irq on read stop", irq_cnt - n0, 1);
    chk("R7 last_rd read", int'(last_rd), 1);
  endtask

  task automatic t_read_cont();
    logic a; logic [7:0] d;
    cpu_wr(5'd7, 8'h5E);
    m_start();
    m_wbyte({DEV, 1'b1}, a);
    m_rbyte(1'b0, d); chk("R3 R8 offset kept, byte 7", int'(d), 'h5E);
    m_stop();
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d; int n0;
    n0 = irq_cnt;
    pull_seen = 1'b0;
    m_start();
    m_wbyte(8'h66, a); chk("R1 foreign address nack", int'(a), 0);
    m_wbyte(8'd0, a);
    m_wbyte(8'hEE, a);
    m_stop();
    chk("R1 no sda activity", int'(pull_seen), 0);
    cpu_rd(5'd0, d); chk("R1 byte 0 unchanged", int'(d), 0);
    chk("R7 no irq when not addressed", irq_cnt - n0, 0);
  endtask

  task automatic t_oor();
    logic a; logic [7:0] d;
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd30, a);
    m_wbyte(8'h11, a); chk("R4 ack at 30", int'(a), 1);
    m_wbyte(8'h22, a); chk("R4 ack at 31", int'(a), 1);
    m_wbyte(8'h33, a); chk("R4 nack past end", int'(a), 0);
    m_stop();
    cpu_rd(5'd30, d); chk("R4 byte 30", int'(d), 'h11);
    cpu_rd(5'd31, d); chk("R4 byte 31", int'(d), 'h22);
    cpu_rd(5'd0, d);  chk("R4 no wrap to 0", int'(d), 0);
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd31, a);
    m_start();
    m_wbyte({DEV, 1'b1}, a);
    m_rbyte(1'b1, d); chk("R4 read 31", int'(d), 'h22);
    m_rbyte(1'b0, d); chk("R4 read past end", int'(d), 'hFF);
    m_stop();
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd40, a); chk("R4 offset 40 acked", int'(a), 1);
    m_stop();
    m_start();
    m_wbyte({DEV, 1'b1}, a);
    m_rbyte(1'b0, d); chk("R4 loaded out of range reads FF", int'(d), 'hFF);
    m_stop();
  endtask

  task automatic t_irq_off();
    logic a; int n0;
    irq_en = 1'b0;
    n0 = irq_cnt;
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd2, a);
    m_stop();
    chk("R7 no irq when disabled", irq_cnt - n0, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_cpu_mid();
    logic a, r; logic [7:0] d;
    cpu_wr(5'd10, 8'h10);
    cpu_wr(5'd11, 8'h20);
    m_start();
    m_wbyte({DEV, 1'b0}, a);
    m_wbyte(8'd10, a);
    m_start();
    m_wbyte({DEV, 1'b1}, a);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      if (i == 4) begin
        cpu_wr(5'd10, 8'h99);
        cpu_wr(5'd11, 8'h77);
      end
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(1'b0, r);
    chk("R9 current byte latched", int'(d), 'h10);
    m_rbyte(1'b0, d); chk("R9 next byte fresh", int'(d), 'h77);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_read_rs();
    t_read_cont();
    t_mismatch();
    t_oor();
    t_irq_off();
    t_cpu_mid();
    chk("R5 pull changes only while scl low", bad_edge, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule